// File: doc/BRIEF.md
# Expandable queue address decoder

This block sits at the front of a multi-queue buffer that may be one of up to eight identical devices chained on a common address bus. Each of the two ports, write and read, presents an address with an address-enable strobe. The decoder captures the address, checks whether the device field names this device, extracts the queue index, and recognises the null-queue bit. A null-queue address targets the device without selecting any real queue.

The device number and the master/slave strap are sampled while reset is held and are frozen afterwards. The decoder also decides which chained device drives the shared full-flag and output-valid lines. After reset the master drives both lines. After that, whichever device was last addressed on a port drives that port's line. The output-valid line follows the read selection one stage later, to match the read data pipeline. The flag values themselves are produced elsewhere. This block supplies only the selection state, the per-access gating and the drive enables.

The design uses a single clock for both ports and a synchronous active-low reset.

Top module: `qaddr_decode`

## Requirements
- R1: While reset is held and on the first cycle after it is released, a device strapped as master shows `wr_dev_sel`, `rd_dev_sel`, `full_oe` and `ov_oe` all 1. A device strapped as slave shows all four at 0. In both cases the queue indices are 0 and the null indications are 0.
- R2: A port captures its address only on a rising edge where its address enable is 1. At any other edge the selection outputs of that port keep their value.
- R3: The address layout is as follows. Bits [3:0] give the queue index, bit [4] is the null-queue flag (1 = null queue), and bits [7:5] give the device number. The captured index and null flag appear on `*_qidx` and `*_null` in the cycle after the capturing edge.
- R4: After a capture, `*_dev_sel` is 1 exactly when address bits [7:5] equal the device number latched during reset.
- R5: Changes to `dev_id_strap` and `master_strap` after reset has been released have no effect on device matching or on ownership.
- R6: `full_oe` equals the write port's device selection. It switches in the cycle after a write-port capture and never switches at any other time.
- R7: `ov_qidx`, `ov_null` and `ov_oe` take the read port's selection one cycle after `rd_qidx`, `rd_null` and `rd_dev_sel` do. That is two cycles after the capturing edge.
- R8: `wr_go` equals `wr_req` when the write port has this device selected on a real queue, and is 0 otherwise. `rd_go` behaves in the same way for the read port.
- R9: Selecting the null queue on this device keeps `full_oe` or `ov_oe` at 1, while `wr_go` or `rd_go` stays 0.
- R10: While `cfg_done` is 0, address enables are ignored and all selection outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous master reset, active low; straps sampled while low |
| dev_id_strap | input | 3 | Device number strap |
| master_strap | input | 1 | 1 = master device, 0 = slave |
| cfg_done | input | 1 | Configuration finished; gates queue selection |
| wr_addr | input | 8 | Write-port queue address |
| wr_addr_en | input | 1 | Write-port address enable |
| wr_req | input | 1 | Write access request |
| rd_addr | input | 8 | Read-port queue address |
| rd_addr_en | input | 1 | Read-port address enable |
| rd_req | input | 1 | Read access request |
| wr_qidx | output | 4 | Selected write queue |
| wr_null | output | 1 | Write port addresses the null queue |
| wr_dev_sel | output | 1 | This device selected on the write port |
| wr_go | output | 1 | Gated write access |
| full_oe | output | 1 | Drive enable for the shared full-flag line |
| rd_qidx | output | 4 | Selected read queue |
| rd_null | output | 1 | Read port addresses the null queue |
| rd_dev_sel | output | 1 | This device selected on the read port |
| rd_go | output | 1 | Gated read access |
| ov_qidx | output | 4 | Queue the output-valid flag currently describes |
| ov_null | output | 1 | Output-valid stage refers to the null queue |
| ov_oe | output | 1 | Drive enable for the shared output-valid line |

## Verification
The bench uses the default widths: a 4-bit queue field and a 3-bit device field, with the device strapped to number 5. These values exercise matching and non-matching device numbers, as well as a null queue on this device. Resets are run as both master and slave, so that both ownership start states are observed. The straps are changed after reset to show that the frozen number, not the live pin, decides matching. The read path is sampled on two consecutive cycles to separate the selection stage from the output-valid stage.

// File: rtl/qad_pkg.sv
package qad_pkg;
    localparam int QAD_QSEL_W = 4;
    localparam int QAD_DEV_W  = 3;

    function automatic int qad_addr_w(input int qsel_w, input int dev_w);
        return dev_w + 1 + qsel_w;
    endfunction
endpackage

// File: rtl/qad_strap.sv
module qad_strap #(
    parameter int DEV_W = qad_pkg::QAD_DEV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEV_W-1:0] id_pin,
    input  logic             mst_pin,
    output logic [DEV_W-1:0] id_q,
    output logic             mst_q
);
    typedef struct packed {
        logic [DEV_W-1:0] id;
        logic             mst;
    } strap_t;

    strap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.id  = id_pin;
            st_d.mst = mst_pin;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign id_q  = st_q.id;
    assign mst_q = st_q.mst;

    // R5: straps frozen once reset is released
    a_r5_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(id_q) && $stable(mst_q)));
endmodule

// File: rtl/qad_port.sv
module qad_port #(
    parameter int QSEL_W = qad_pkg::QAD_QSEL_W,
    parameter int DEV_W  = qad_pkg::QAD_DEV_W,
    localparam int ADDR_W = DEV_W + 1 + QSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_sel,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic              cfg_done,
    input  logic              addr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              req,
    output logic [QSEL_W-1:0] qidx,
    output logic              nul,
    output logic              sel,
    output logic              go
);
    localparam int NULL_BIT = QSEL_W;

    typedef struct packed {
        logic [QSEL_W-1:0] qidx;
        logic              nul;
        logic              sel;
    } sel_t;

    sel_t ps_d, ps_q;
    logic capture;

    assign capture = addr_en && cfg_done;

    always_comb begin
        ps_d = ps_q;
        if (!rst_n) begin
            ps_d.qidx = '0;
            ps_d.nul  = 1'b0;
            ps_d.sel  = rst_sel;
        end else if (capture) begin
            ps_d.qidx = addr[QSEL_W-1:0];
            ps_d.nul  = addr[NULL_BIT];
            ps_d.sel  = (addr[ADDR_W-1 -: DEV_W] == dev_id);
        end
    end

    always_ff @(posedge clk) begin
        ps_q <= ps_d;
    end

    assign qidx = ps_q.qidx;
    assign nul  = ps_q.nul;
    assign sel  = ps_q.sel;
    assign go   = req && ps_q.sel && !ps_q.nul;

    // R2, R10: no capture means the selection holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(qidx) && $stable(nul) && $stable(sel)));

    // R3: captured fields land on the next cycle
    a_r3_fields: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (qidx == $past(addr[QSEL_W-1:0]) && nul == $past(addr[NULL_BIT])));

    // R4: device match against the latched number
    a_r4_match: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (sel == ($past(addr[ADDR_W-1 -: DEV_W]) == $past(dev_id))));
endmodule

// File: rtl/qad_ov_stage.sv
module qad_ov_stage #(
    parameter int QSEL_W = qad_pkg::QAD_QSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_sel,
    input  logic [QSEL_W-1:0] in_qidx,
    input  logic              in_nul,
    input  logic              in_sel,
    output logic [QSEL_W-1:0] out_qidx,
    output logic              out_nul,
    output logic              out_sel
);
    typedef struct packed {
        logic [QSEL_W-1:0] qidx;
        logic              nul;
        logic              sel;
    } ov_t;

    ov_t ov_d, ov_q;

    always_comb begin
        ov_d = ov_q;
        if (!rst_n) begin
            ov_d.qidx = '0;
            ov_d.nul  = 1'b0;
            ov_d.sel  = rst_sel;
        end else begin
            ov_d.qidx = in_qidx;
            ov_d.nul  = in_nul;
            ov_d.sel  = in_sel;
        end
    end

    always_ff @(posedge clk) begin
        ov_q <= ov_d;
    end

    assign out_qidx = ov_q.qidx;
    assign out_nul  = ov_q.nul;
    assign out_sel  = ov_q.sel;
endmodule

// File: rtl/qaddr_decode.sv
module qaddr_decode #(
    parameter int QSEL_W = qad_pkg::QAD_QSEL_W,
    parameter int DEV_W  = qad_pkg::QAD_DEV_W,
    localparam int ADDR_W = DEV_W + 1 + QSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_id_strap,
    input  logic              master_strap,
    input  logic              cfg_done,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_addr_en,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_addr_en,
    input  logic              rd_req,
    output logic [QSEL_W-1:0] wr_qidx,
    output logic              wr_null,
    output logic              wr_dev_sel,
    output logic              wr_go,
    output logic              full_oe,
    output logic [QSEL_W-1:0] rd_qidx,
    output logic              rd_null,
    output logic              rd_dev_sel,
    output logic              rd_go,
    output logic [QSEL_W-1:0] ov_qidx,
    output logic              ov_null,
    output logic              ov_oe
);
    logic [DEV_W-1:0] id_q;
    logic             mst_q;

    qad_strap #(.DEV_W(DEV_W)) i_strap (
        .clk(clk), .rst_n(rst_n), .id_pin(dev_id_strap), .mst_pin(master_strap),
        .id_q(id_q), .mst_q(mst_q)
    );

    qad_port #(.QSEL_W(QSEL_W), .DEV_W(DEV_W)) i_wr_port (
        .clk(clk), .rst_n(rst_n), .rst_sel(master_strap), .dev_id(id_q),
        .cfg_done(cfg_done), .addr_en(wr_addr_en), .addr(wr_addr), .req(wr_req),
        .qidx(wr_qidx), .nul(wr_null), .sel(wr_dev_sel), .go(wr_go)
    );

    qad_port #(.QSEL_W(QSEL_W), .DEV_W(DEV_W)) i_rd_port (
        .clk(clk), .rst_n(rst_n), .rst_sel(master_strap), .dev_id(id_q),
        .cfg_done(cfg_done), .addr_en(rd_addr_en), .addr(rd_addr), .req(rd_req),
        .qidx(rd_qidx), .nul(rd_null), .sel(rd_dev_sel), .go(rd_go)
    );

    qad_ov_stage #(.QSEL_W(QSEL_W)) i_ov_stage (
        .clk(clk), .rst_n(rst_n), .rst_sel(master_strap),
        .in_qidx(rd_qidx), .in_nul(rd_null), .in_sel(rd_dev_sel),
        .out_qidx(ov_qidx), .out_nul(ov_null), .out_sel(ov_oe)
    );

    assign full_oe = wr_dev_sel;

    // R6: full-flag ownership moves only after a write-port capture
    a_r6_full_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_addr_en && cfg_done) |=> $stable(full_oe));

    // R7: output-valid stage trails the read selection by one cycle
    a_r7_ov_trail: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ov_qidx == $past(rd_qidx) && ov_oe == $past(rd_dev_sel)
                   && ov_null == $past(rd_null)));

    // R1: reset ownership follows the latched master strap
    a_r1_reset_owner: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |=> (!rst_n || (full_oe == mst_q && ov_oe == mst_q)));
endmodule

// File: tb/test_qaddr_decode.sv
module test_qaddr_decode;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dev_id_strap = 3'd5;
    logic       master_strap = 1'b1;
    logic       cfg_done = 1'b0;
    logic [7:0] wr_addr = '0;
    logic       wr_addr_en = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       rd_addr_en = 1'b0;
    logic       rd_req = 1'b0;
    logic [3:0] wr_qidx, rd_qidx, ov_qidx;
    logic       wr_null, wr_dev_sel, wr_go, full_oe;
    logic       rd_null, rd_dev_sel, rd_go, ov_null, ov_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    qaddr_decode i_qaddr_decode (
        .clk(clk), .rst_n(rst_n), .dev_id_strap(dev_id_strap), .master_strap(master_strap),
        .cfg_done(cfg_done), .wr_addr(wr_addr), .wr_addr_en(wr_addr_en), .wr_req(wr_req),
        .rd_addr(rd_addr), .rd_addr_en(rd_addr_en), .rd_req(rd_req),
        .wr_qidx(wr_qidx), .wr_null(wr_null), .wr_dev_sel(wr_dev_sel), .wr_go(wr_go),
        .full_oe(full_oe), .rd_qidx(rd_qidx), .rd_null(rd_null), .rd_dev_sel(rd_dev_sel),
        .rd_go(rd_go), .ov_qidx(ov_qidx), .ov_null(ov_null), .ov_oe(ov_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit mst, input logic [2:0] id);
        @(negedge clk);
        rst_n = 1'b0; master_strap = mst; dev_id_strap = id;
        cfg_done = 1'b0; wr_addr_en = 1'b0; rd_addr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sel_wr(input logic [7:0] a);
        wr_addr = a; wr_addr_en = 1'b1;
        @(negedge clk);
        wr_addr_en = 1'b0;
    endtask

    task automatic sel_rd(input logic [7:0] a);
        rd_addr = a; rd_addr_en = 1'b1;
        @(negedge clk);
        rd_addr_en = 1'b0;
    endtask

    task automatic t_reset_master();
        do_reset(1'b1, 3'd5);
        chk("R1 master wr_dev_sel", 32'(wr_dev_sel), 1);
        chk("R1 master rd_dev_sel", 32'(rd_dev_sel), 1);
        chk("R1 master full_oe", 32'(full_oe), 1);
        chk("R1 master ov_oe", 32'(ov_oe), 1);
        chk("R1 master qidx", 32'({wr_qidx, rd_qidx, ov_qidx}), 0);
        chk("R1 master null", 32'({wr_null, rd_null, ov_null}), 0);
    endtask

    task automatic t_reset_slave();
        do_reset(1'b0, 3'd5);
        chk("R1 slave sel", 32'({wr_dev_sel, rd_dev_sel}), 0);
        chk("R1 slave oe", 32'({full_oe, ov_oe}), 0);
        chk("R1 slave qidx", 32'({wr_qidx, rd_qidx}), 0);
    endtask

    task automatic t_cfg_gate();
        cfg_done = 1'b0;
        sel_wr(8'hA9);
        @(negedge clk);
        chk("R10 cfg low wr_dev_sel", 32'(wr_dev_sel), 0);
        chk("R10 cfg low wr_qidx", 32'(wr_qidx), 0);
        chk("R10 cfg low full_oe", 32'(full_oe), 0);
        cfg_done = 1'b1;
    endtask

    task automatic t_match();
        sel_wr(8'hA9);
        chk("R3 wr_qidx", 32'(wr_qidx), 9);
        chk("R3 wr_null", 32'(wr_null), 0);
        chk("R4 wr match", 32'(wr_dev_sel), 1);
        chk("R6 full_oe take", 32'(full_oe), 1);
        wr_addr = 8'h43;
        @(negedge clk);
        chk("R2 no enable hold qidx", 32'(wr_qidx), 9);
        chk("R2 no enable hold sel", 32'(wr_dev_sel), 1);
        sel_wr(8'h43);
        chk("R4 wr other dev", 32'(wr_dev_sel), 0);
        chk("R3 wr_qidx other", 32'(wr_qidx), 3);
        chk("R6 full_oe release", 32'(full_oe), 0);
    endtask

    task automatic t_go();
        sel_wr(8'hAC);
        wr_req = 1'b1; #1;
        chk("R8 wr_go real queue", 32'(wr_go), 1);
        wr_req = 1'b0; #1;
        chk("R8 wr_go no req", 32'(wr_go), 0);
        @(negedge clk);
        sel_wr(8'h4C);
        wr_req = 1'b1; #1;
        chk("R8 wr_go other dev", 32'(wr_go), 0);
        wr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_null();
        sel_wr(8'hB0);
        sel_rd(8'hB0);
        @(negedge clk);
        wr_req = 1'b1; rd_req = 1'b1; #1;
        chk("R9 null wr_null", 32'(wr_null), 1);
        chk("R9 null full_oe kept", 32'(full_oe), 1);
        chk("R9 null ov_oe kept", 32'(ov_oe), 1);
        chk("R9 null wr_go blocked", 32'(wr_go), 0);
        chk("R9 null rd_go blocked", 32'(rd_go), 0);
        wr_req = 1'b0; rd_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_ov();
        sel_rd(8'hA7);
        @(negedge clk);
        sel_rd(8'h52);
        chk("R7 rd stage new", 32'(rd_qidx), 2);
        chk("R7 rd sel other", 32'(rd_dev_sel), 0);
        chk("R7 ov stage old qidx", 32'(ov_qidx), 7);
        chk("R7 ov stage old oe", 32'(ov_oe), 1);
        @(negedge clk);
        chk("R7 ov stage new qidx", 32'(ov_qidx), 2);
        chk("R7 ov stage new oe", 32'(ov_oe), 0);
        sel_rd(8'hA5);
        rd_req = 1'b1; #1;
        chk("R8 rd_go real queue", 32'(rd_go), 1);
        rd_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_strap_change();
        dev_id_strap = 3'd2; master_strap = 1'b0;
        @(negedge clk);
        sel_wr(8'hA9);
        chk("R5 old id still matches", 32'(wr_dev_sel), 1);
        sel_wr(8'h49);
        chk("R5 new pin id ignored", 32'(wr_dev_sel), 0);
        sel_rd(8'hA1);
        chk("R5 rd old id matches", 32'(rd_dev_sel), 1);
    endtask

    initial begin
        t_reset_slave();
        t_cfg_gate();
        t_match();
        t_reset_master();
        cfg_done = 1'b1;
        t_go();
        t_null();
        t_ov();
        t_strap_change();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule